// File: doc/BRIEF.md
# Duplicated Dual-Read Write-Through Data Cache

This block is a small first-level data cache that can complete two load lookups in every clock. It does not use a multi-port RAM. It keeps two identical copies of the tag, valid and data storage instead. Load port 0 always reads copy 0 and load port 1 always reads copy 1. Any write, whether a line fill or a store hit, is applied to both copies in the same cycle, so the copies never drift apart.

The cache is direct mapped, with 32-byte lines and 64-bit words, and holds 8 KB in each copy. Stores use the write-through policy. A store hit merges its enabled bytes into both copies. Every store, hit or miss, is passed on unchanged to a downstream write port one cycle later. A store miss does not allocate a line.

A load that misses is answered with its hit flag low. The surrounding logic then supplies the whole line through the fill port and retries the load. A fill takes one cycle. During that cycle neither load port accepts a request.

Top module: `dual_read_dcache`

## Requirements
- R1: Each load port accepts a request in any cycle where `ld_ready` is high. Its response (`ldN_rsp_valid`) appears exactly 2 clocks after acceptance. Both ports can respond, and both can hit, in the same cycle.
- R2: The address is split into fields. Bits [2:0] are ignored. Bits [4:3] select the word in the line. Bits [12:5] are the line index. Bits [31:13] are the tag. A load hits only if the indexed line is valid and its tag matches. On a hit the response returns the selected 64-bit word.
- R3: A load whose line is invalid, or whose line holds another tag, responds with `ldN_hit` low.
- R4: A fill writes the whole line into both copies, with word k taken from `fill_data[64k+63:64k]`. It marks the line valid with the fill tag. After the fill, loads of that line hit on either port.
- R5: `ld_ready` is low in exactly the cycles where `fill_valid` is high. A load presented in such a cycle is not accepted and produces no response.
- R6: A store hit updates only the bytes whose `st_be` bit is set. Bit b covers data bits [8b+7:8b]. The update is made in both copies, and both load ports see it.
- R7: A store miss does not allocate. A later load of the same address still misses.
- R8: Every store appears on the write-through port one clock later, with address, data and byte enables unchanged, whether it hit or missed.
- R9: A load in the same cycle as a store to the same word returns the data from before the store. A load one cycle later returns the stored data.
- R10: Reset invalidates every line. After reset no response and no write-through is pending, and every load misses until a fill arrives.
- R11: If a store and a fill target the same line in the same cycle and the store tag equals the fill tag, the stored bytes are merged on top of the fill data. If the tags differ, the store does not touch the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_ready | output | 1 | Both load ports can accept a request this cycle |
| ld0_valid | input | 1 | Load request on port 0 |
| ld0_addr | input | 32 | Byte address of the port 0 load |
| ld0_rsp_valid | output | 1 | Port 0 response valid |
| ld0_hit | output | 1 | Port 0 response hit |
| ld0_data | output | 64 | Port 0 load data |
| ld1_valid | input | 1 | Load request on port 1 |
| ld1_addr | input | 32 | Byte address of the port 1 load |
| ld1_rsp_valid | output | 1 | Port 1 response valid |
| ld1_hit | output | 1 | Port 1 response hit |
| ld1_data | output | 64 | Port 1 load data |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| fill_valid | input | 1 | Line fill |
| fill_addr | input | 32 | Address within the filled line |
| fill_data | input | 256 | Line contents, word 0 in the low bits |
| wt_valid | output | 1 | Write-through store valid |
| wt_addr | output | 32 | Write-through address |
| wt_data | output | 64 | Write-through data |
| wt_be | output | 8 | Write-through byte enables |

## Verification
The hardest case to reach from the ports is a store and a fill landing on the same line in the same cycle, together with loads on both ports. Only with that mix does the merge order and the lockstep update of both copies show. Random traffic is confined to three tags and six line indices, so hits, conflicts and same-word store/load pairs happen often. Directed cycles force the fill-plus-store merge and the same-cycle load-after-store case, and the bench model applies the fill before the store when it predicts each response.

// File: rtl/dual_read_dcache.sv
module dual_read_dcache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 8192
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    ld_ready,
  input  logic                    ld0_valid,
  input  logic [ADDR_W-1:0]       ld0_addr,
  output logic                    ld0_rsp_valid,
  output logic                    ld0_hit,
  output logic [DATA_W-1:0]       ld0_data,
  input  logic                    ld1_valid,
  input  logic [ADDR_W-1:0]       ld1_addr,
  output logic                    ld1_rsp_valid,
  output logic                    ld1_hit,
  output logic [DATA_W-1:0]       ld1_data,
  input  logic                    st_valid,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic [DATA_W/8-1:0]     st_be,
  input  logic                    fill_valid,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  output logic                    wt_valid,
  output logic [ADDR_W-1:0]       wt_addr,
  output logic [DATA_W-1:0]       wt_data,
  output logic [DATA_W/8-1:0]     wt_be
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WPL        = LINE_BYTES / WORD_BYTES;
  localparam int LINES      = CACHE_BYTES / LINE_BYTES;
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(WPL);
  localparam int OFS_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(LINES);
  localparam int TAG_W      = ADDR_W - OFS_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WSEL_W];
  endfunction

  logic [IDX_W-1:0]  st_idx, fill_idx;
  logic [TAG_W-1:0]  st_tag, fill_tag;
  logic [WSEL_W-1:0] st_word;
  logic              st_on_fill;

  assign st_idx     = idx_of(st_addr);
  assign st_tag     = tag_of(st_addr);
  assign st_word    = word_of(st_addr);
  assign fill_idx   = idx_of(fill_addr);
  assign fill_tag   = tag_of(fill_addr);
  assign st_on_fill = fill_valid && (fill_idx == st_idx);
  assign ld_ready   = ~fill_valid;

  for (genvar c = 0; c < 2; c++) begin : copy
    logic [TAG_W-1:0]  tagm [LINES];
    logic [DATA_W-1:0] datm [LINES*WPL];
    logic [LINES-1:0]  vld;
    logic [ADDR_W-1:0] la;
    logic              acc, acc_q, rvld_q, rsp_v, rsp_hit, st_hit;
    logic [TAG_W-1:0]  rtag_q, qtag_q;
    logic [DATA_W-1:0] rdat_q, rsp_dat;

    assign la     = (c == 0) ? ld0_addr : ld1_addr;
    assign acc    = ((c == 0) ? ld0_valid : ld1_valid) & ~fill_valid;
    assign st_hit = st_valid && (st_on_fill ? (fill_tag == st_tag)
                                            : (vld[st_idx] && tagm[st_idx] == st_tag));

    always_ff @(posedge clk) begin
      if (rst) vld <= '0;
      else if (fill_valid) vld[fill_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (fill_valid) begin
        tagm[fill_idx] <= fill_tag;
        for (int w = 0; w < WPL; w++)
          datm[{fill_idx, WSEL_W'(w)}] <= fill_data[w*DATA_W +: DATA_W];
      end
      if (st_hit)
        for (int b = 0; b < WORD_BYTES; b++)
          if (st_be[b]) datm[{st_idx, st_word}][b*8 +: 8] <= st_data[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
      rtag_q  <= tagm[idx_of(la)];
      rvld_q  <= vld[idx_of(la)];
      rdat_q  <= datm[{idx_of(la), word_of(la)}];
      qtag_q  <= tag_of(la);
      rsp_dat <= rdat_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q   <= 1'b0;
        rsp_v   <= 1'b0;
        rsp_hit <= 1'b0;
      end else begin
        acc_q   <= acc;
        rsp_v   <= acc_q;
        rsp_hit <= acc_q && rvld_q && (rtag_q == qtag_q);
      end
    end

    assert_load_latency_R1: assert property (@(posedge clk) disable iff (rst)
      acc |-> ##2 rsp_v);
    assert_fill_stall_R5: assert property (@(posedge clk) disable iff (rst)
      fill_valid |-> ##2 !rsp_v);
    assert_hit_needs_response_R2: assert property (@(posedge clk) disable iff (rst)
      rsp_hit |-> rsp_v);
  end

  assign ld0_rsp_valid = copy[0].rsp_v;
  assign ld0_hit       = copy[0].rsp_hit;
  assign ld0_data      = copy[0].rsp_dat;
  assign ld1_rsp_valid = copy[1].rsp_v;
  assign ld1_hit       = copy[1].rsp_hit;
  assign ld1_data      = copy[1].rsp_dat;

  assert_copies_agree_R4: assert property (@(posedge clk) disable iff (rst)
    (copy[0].vld[st_idx] == copy[1].vld[st_idx]) &&
    (!copy[0].vld[st_idx] ||
     (copy[0].tagm[st_idx] == copy[1].tagm[st_idx] &&
      copy[0].datm[{st_idx, st_word}] == copy[1].datm[{st_idx, st_word}])));
  assert_store_hit_lockstep_R6: assert property (@(posedge clk) disable iff (rst)
    copy[0].st_hit == copy[1].st_hit);

  always_ff @(posedge clk) begin
    if (rst) wt_valid <= 1'b0;
    else     wt_valid <= st_valid;
    wt_addr <= st_addr;
    wt_data <= st_data;
    wt_be   <= st_be;
  end

  assert_write_through_R8: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> wt_valid && wt_addr == $past(st_addr) &&
                 wt_data == $past(st_data) && wt_be == $past(st_be));
  assert_idle_write_port_R8: assert property (@(posedge clk) disable iff (rst)
    !st_valid |=> !wt_valid);
endmodule

// File: tb/dual_read_dcache_test.sv
module dual_read_dcache_test;
  logic         clk = 0, rst = 1;
  logic         ld_ready;
  logic         ld0_valid = 0, ld1_valid = 0, st_valid = 0, fill_valid = 0;
  logic [31:0]  ld0_addr = 0, ld1_addr = 0, st_addr = 0, fill_addr = 0;
  logic         ld0_rsp_valid, ld1_rsp_valid, ld0_hit, ld1_hit, wt_valid;
  logic [63:0]  ld0_data, ld1_data, st_data = 0, wt_data;
  logic [7:0]   st_be = 0, wt_be;
  logic [255:0] fill_data = 0;
  logic [31:0]  wt_addr;

  dual_read_dcache uut (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [18:0] mtag [256];
  bit          mval [256];
  logic [63:0] mdat [1024];

  bit          p_v   [2][2];
  bit          p_hit [2][2];
  logic [63:0] p_dat [2][2];
  string       p_lbl [2][2];
  bit          w_v = 0;
  logic [31:0] w_a = 0;
  logic [63:0] w_d = 0;
  logic [7:0]  w_b = 0;

  function automatic logic [31:0] mk(input int t, input int i, input int w);
    return (32'(t) << 13) | (32'(i) << 5) | (32'(w) << 3);
  endfunction
  function automatic bit model_hit(input logic [31:0] a);
    return mval[a[12:5]] && mtag[a[12:5]] == a[31:13];
  endfunction
  function automatic logic [63:0] model_word(input logic [31:0] a);
    return mdat[{a[12:5], a[4:3]}];
  endfunction
  function automatic logic [255:0] pattern(input int s);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = 32'(s * 131 + k * 7919) ^ 32'hA5A5_0000;
    return v;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cycle(input bit fv, input logic [31:0] fa, input logic [255:0] fd,
                       input bit l0v, input logic [31:0] l0a,
                       input bit l1v, input logic [31:0] l1a,
                       input bit sv, input logic [31:0] sa, input logic [63:0] sd,
                       input logic [7:0] sb, input string lbl);
    bit          rv, rh;
    logic [63:0] rd;
    bit          lv [2];
    logic [31:0] laddr [2];
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      rv = (p == 0) ? ld0_rsp_valid : ld1_rsp_valid;
      rh = (p == 0) ? ld0_hit : ld1_hit;
      rd = (p == 0) ? ld0_data : ld1_data;
      chk(rv == p_v[1][p], {p_lbl[1][p], " response valid (R1/R5)"}, 64'(rv), 64'(p_v[1][p]));
      if (p_v[1][p]) begin
        chk(rh == p_hit[1][p], {p_lbl[1][p], " hit flag"}, 64'(rh), 64'(p_hit[1][p]));
        if (p_hit[1][p]) chk(rd == p_dat[1][p], {p_lbl[1][p], " load data"}, rd, p_dat[1][p]);
      end
    end
    chk(wt_valid == w_v, "R8 write-through valid", 64'(wt_valid), 64'(w_v));
    if (w_v) begin
      chk(wt_addr == w_a, "R8 write-through addr", 64'(wt_addr), 64'(w_a));
      chk(wt_data == w_d, "R8 write-through data", wt_data, w_d);
      chk(wt_be == w_b, "R8 write-through byte enables", 64'(wt_be), 64'(w_b));
    end
    lv[0] = l0v; lv[1] = l1v; laddr[0] = l0a; laddr[1] = l1a;
    for (int p = 0; p < 2; p++) begin
      p_v[1][p]   = p_v[0][p];
      p_hit[1][p] = p_hit[0][p];
      p_dat[1][p] = p_dat[0][p];
      p_lbl[1][p] = p_lbl[0][p];
      p_v[0][p]   = lv[p] && !fv;
      p_hit[0][p] = model_hit(laddr[p]);
      p_dat[0][p] = model_word(laddr[p]);
      if (lbl != "") p_lbl[0][p] = lbl;
      else if (sv && sa[31:3] == laddr[p][31:3]) p_lbl[0][p] = "R9";
      else p_lbl[0][p] = p_hit[0][p] ? "R2" : "R3";
    end
    w_v = sv; w_a = sa; w_d = sd; w_b = sb;
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    ld0_valid = l0v; ld0_addr = l0a; ld1_valid = l1v; ld1_addr = l1a;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    #1;
    chk(ld_ready == !fv, "R5 ld_ready versus fill", 64'(ld_ready), 64'(!fv));
    if (fv) begin
      mval[fa[12:5]] = 1;
      mtag[fa[12:5]] = fa[31:13];
      for (int w = 0; w < 4; w++) mdat[{fa[12:5], 2'(w)}] = fd[w*64 +: 64];
    end
    if (sv && model_hit(sa))
      for (int b = 0; b < 8; b++)
        if (sb[b]) mdat[{sa[12:5], sa[4:3]}][b*8 +: 8] = sd[b*8 +: 8];
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] la, lb, lc, ld;
    for (int i = 0; i < 256; i++) begin mval[i] = 0; mtag[i] = 0; end
    for (int i = 0; i < 1024; i++) mdat[i] = 0;
    for (int s = 0; s < 2; s++) for (int p = 0; p < 2; p++) begin
      p_v[s][p] = 0; p_hit[s][p] = 0; p_dat[s][p] = 0; p_lbl[s][p] = "R1";
    end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(ld0_rsp_valid == 0 && ld1_rsp_valid == 0, "R10 reset: no response", 64'(ld0_rsp_valid | ld1_rsp_valid), 0);
    chk(wt_valid == 0, "R10 reset: no write-through", 64'(wt_valid), 0);
    chk(ld_ready == 1, "R10 reset: ld_ready high", 64'(ld_ready), 1);
    rst = 0;

    la = mk(1, 2, 1); lb = mk(2, 2, 1); lc = mk(1, 3, 0); ld = mk(0, 5, 3);
    // R10: everything misses right after reset
    cycle(0, 0, 0, 1, la, 1, ld, 0, 0, 0, 0, "R10");
    // R5: fill with loads present, loads refused
    cycle(1, la, pattern(1), 1, la, 1, mk(1, 2, 3), 0, 0, 0, 0, "R5");
    // R4 and R1: both ports hit the filled line in the same cycle
    cycle(0, 0, 0, 1, la, 1, mk(1, 2, 3), 0, 0, 0, 0, "R4");
    cycle(0, 0, 0, 1, mk(1, 2, 0), 1, mk(1, 2, 2) | 32'h5, 0, 0, 0, 0, "R1");
    // R6: partial store hit, then both ports read it
    cycle(0, 0, 0, 0, 0, 0, 0, 1, la, 64'h1122_3344_5566_7788, 8'h0F, "");
    cycle(0, 0, 0, 1, la, 1, la, 0, 0, 0, 0, "R6");
    // R9: load and store to the same word in one cycle, then a load right after
    cycle(0, 0, 0, 1, mk(1, 2, 2), 1, mk(1, 2, 2), 1, mk(1, 2, 2), 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, "R9");
    cycle(0, 0, 0, 1, mk(1, 2, 2), 1, mk(1, 2, 2), 0, 0, 0, 0, "R9");
    // R7: store miss to a conflicting tag does not allocate
    cycle(0, 0, 0, 0, 0, 0, 0, 1, lb, 64'h0123_4567_89AB_CDEF, 8'hFF, "");
    cycle(0, 0, 0, 1, lb, 1, la, 0, 0, 0, 0, "R7");
    // R11: fill and store to the same line together, matching then differing tag
    cycle(1, lc, pattern(7), 0, 0, 0, 0, 1, lc, 64'hCAFE_0000_0000_F00D, 8'hC3, "");
    cycle(0, 0, 0, 1, lc, 1, lc, 0, 0, 0, 0, "R11");
    cycle(1, mk(2, 3, 0), pattern(9), 0, 0, 0, 0, 1, lc, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "");
    cycle(0, 0, 0, 1, mk(2, 3, 0), 1, lc, 0, 0, 0, 0, "R11");
    idle(); idle();

    for (int n = 0; n < 4000; n++) begin
      bit fv, l0v, l1v, sv;
      fv  = ($urandom % 8) == 0;
      l0v = ($urandom % 4) != 0;
      l1v = ($urandom % 4) != 0;
      sv  = ($urandom % 3) == 0;
      cycle(fv, mk($urandom % 3, $urandom % 6, $urandom % 4),
            {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
            l0v, mk($urandom % 3, $urandom % 6, $urandom % 4) | 32'($urandom % 8),
            l1v, mk($urandom % 3, $urandom % 6, $urandom % 4),
            sv, mk($urandom % 3, $urandom % 6, $urandom % 4),
            {$urandom, $urandom}, 8'($urandom), "");
    end
    idle(); idle();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule